// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for 96 pins, split into three banks of 32. Pin n sits in bank n/32 at bit n mod 32. Software reaches it through a plain 32-bit word port: an address, a write strobe, write data and a combinational read result. For each pin the controller holds an output-enable bit, a driven value and an input-inversion bit. Output values can be changed one bit at a time, without a read-modify-write, through dedicated write-one-to-set and write-one-to-clear words.

Raw pin inputs pass through a two-flop synchroniser inside the block. The synchronised value, optionally inverted, feeds four independent detectors per pin: rising edge, falling edge, high level and low level. A detected condition latches a pending bit that software clears by writing a one. A second read-only word marks which pending bits came from an edge. One interrupt output is the OR of every pending bit in all banks.

The register file is grouped by function. Each group holds one word per bank, and the banks are interleaved at a 4-byte stride: the word address is the group base plus 4 times the bank index.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every output-enable, output value, inversion, enable, pending and edge-mark bit is zero, and `irq` is low.
- R2: A word address is group base + 4*bank, and addr[1:0] must be 0. Bank field addr[3:2] = 3, a misaligned address and group nibble addr[7:4] above 0xA are unmapped: they read as zero and writes to them change nothing.
- R3: Group 0x00 holds the output enables (1 = output, driven onto `pin_oe`). Group 0x20 holds the output values on `pin_out`. A read of 0x20 returns the output value for enabled pins and the synchronised input, uninverted, for the other pins. The input shows in the read two clock edges after the pin changes.
- R4: In a write to group 0x30, each 1 bit forces that output value to 1. In a write to group 0x40, each 1 bit forces it to 0. Zero bits leave the value unchanged. Both groups read as zero.
- R5: With its group 0x50 enable set, a 0-to-1 transition of a pin's effective input sets its pending bit (group 0x90) on the third rising clock edge after the pin changes. A steady high level does not set it again.
- R6: With the group 0x60 enable set, a 1-to-0 transition sets the pending bit. With both edge enables set, either transition sets it.
- R7: With the group 0x70 (high) or 0x80 (low) enable set, the pending bit is set on every cycle the effective input holds that level. A clear written while the level persists does not leave the bit at zero.
- R8: Writing 1s to group 0x90 clears those pending bits, and 0 bits keep them. Group 0xA0 is read-only: a bit reads 1 when an edge detection set the matching pending bit, and it is cleared by the same write to 0x90.
- R9: An inversion bit of 1 (group 0x10) inverts the input before edge and level detection. It does not change the value read from group 0x20.
- R10: `irq` is high exactly when at least one pending bit in any bank is set. It falls only after the last pending bit is cleared.
- R11: When a write clears a pending bit in the same cycle that a new detection sets it, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the word being accessed |
| wr_en | input | 1 | Write strobe, takes effect at the rising clock edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pin_in | input | 96 | Raw asynchronous pin inputs |
| pin_out | output | 96 | Driven output values |
| pin_oe | output | 96 | Output enables, 1 = drive |
| irq | output | 1 | Shared interrupt, OR of all pending bits |

## Verification
A single pin in bank 2 is driven low-high-low with the rising enable set, then with both edge enables set. This shows whether the edge detector reacts to transitions only and not to a held level. The precise cycle check on `irq` confirms the three-register latency from pin to pending bit. A bank 1 pin held at a level is then cleared while the level persists. This separates level detection, which sets the bit again, from edge detection, which does not, and the edge-mark word must stay zero for it. An inverted, quiet bank 0 pin must raise a high-level interrupt while its data readback stays uninverted. Pending bits in two banks at once show that `irq` stays high until the last one is cleared.

// File: rtl/gpio_ctrl_pkg.sv
// Shared constants for the banked GPIO controller.
// Assumes a byte-addressed 32-bit word port with an 8-bit address.
package gpio_ctrl_pkg;

    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;

    // Register group selected by addr[7:4]; the bank is addr[3:2].
    typedef enum logic [3:0] {
        GRP_OE    = 4'h0,
        GRP_INV   = 4'h1,
        GRP_VAL   = 4'h2,
        GRP_SET   = 4'h3,
        GRP_CLR   = 4'h4,
        GRP_RISE  = 4'h5,
        GRP_FALL  = 4'h6,
        GRP_HIGH  = 4'h7,
        GRP_LOW   = 4'h8,
        GRP_PEND  = 4'h9,
        GRP_EMARK = 4'hA
    } grp_e;

endpackage

// File: rtl/gpio_sync2.sv
// Two-flop synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherence is implied.
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] meta_q;

    // Shift the raw inputs through two reset-cleared stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            d_sync <= '0;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// Interrupt detection for one bank: inversion, edge and level detection,
// write-one-to-clear pending bits and an edge-origin mark per pin.
// Assumes pin_sync is already synchronised to clk.
module gpio_irq_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] inv,
    input  logic [W-1:0] en_rise,
    input  logic [W-1:0] en_fall,
    input  logic [W-1:0] en_high,
    input  logic [W-1:0] en_low,
    input  logic [W-1:0] w1c_mask,
    output logic [W-1:0] pend,
    output logic [W-1:0] edge_seen
);

    logic [W-1:0] eff;
    logic [W-1:0] prev_q;
    logic [W-1:0] edge_hit;
    logic [W-1:0] level_hit;

    // Apply inversion and form this cycle's detection events.
    always_comb begin
        eff       = pin_sync ^ inv;
        edge_hit  = (en_rise & eff & ~prev_q) | (en_fall & ~eff & prev_q);
        level_hit = (en_high & eff) | (en_low & ~eff);
    end

    // Remember the effective input and update pending state; new events win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            pend      <= '0;
            edge_seen <= '0;
        end else begin
            prev_q    <= eff;
            pend      <= (pend & ~w1c_mask) | edge_hit | level_hit;
            edge_seen <= (edge_seen & ~w1c_mask) | edge_hit;
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Banked GPIO controller: function-grouped registers with banks interleaved
// at a 4-byte stride, atomic set/clear of outputs, per-pin edge/level
// interrupts and one shared interrupt line.
// Assumes BANK_W equals the 32-bit word width and NUM_BANKS is at most 4.
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [WORD_W-1:0]           rd_data,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic                        irq
);

    localparam int PINS = NUM_BANKS * BANK_W;

    logic [BANK_W-1:0] oe_q    [NUM_BANKS];
    logic [BANK_W-1:0] inv_q   [NUM_BANKS];
    logic [BANK_W-1:0] val_q   [NUM_BANKS];
    logic [BANK_W-1:0] rise_q  [NUM_BANKS];
    logic [BANK_W-1:0] fall_q  [NUM_BANKS];
    logic [BANK_W-1:0] high_q  [NUM_BANKS];
    logic [BANK_W-1:0] low_q   [NUM_BANKS];
    logic [BANK_W-1:0] sync_w  [NUM_BANKS];
    logic [BANK_W-1:0] pend_w  [NUM_BANKS];
    logic [BANK_W-1:0] emark_w [NUM_BANKS];
    logic [BANK_W-1:0] w1c_w   [NUM_BANKS];

    logic [3:0] grp;
    logic [1:0] bsel;
    logic       hit;

    // Split the address into group and bank and flag mapped words.
    always_comb begin
        grp  = addr[7:4];
        bsel = addr[3:2];
        hit  = (addr[1:0] == 2'b00) && (32'(bsel) < NUM_BANKS) && (grp <= GRP_EMARK);
    end

    // Per-bank synchroniser, detector and pin wiring.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign w1c_w[b] = (wr_en && hit && grp == GRP_PEND && bsel == 2'(b))
                          ? wr_data[BANK_W-1:0] : '0;

        gpio_sync2 #(.W(BANK_W)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (pin_in[b*BANK_W +: BANK_W]),
            .d_sync  (sync_w[b])
        );

        gpio_irq_bank #(.W(BANK_W)) u_irq (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_sync  (sync_w[b]),
            .inv       (inv_q[b]),
            .en_rise   (rise_q[b]),
            .en_fall   (fall_q[b]),
            .en_high   (high_q[b]),
            .en_low    (low_q[b]),
            .w1c_mask  (w1c_w[b]),
            .pend      (pend_w[b]),
            .edge_seen (emark_w[b])
        );

        assign pin_out[b*BANK_W +: BANK_W] = val_q[b];
        assign pin_oe[b*BANK_W +: BANK_W]  = oe_q[b];
    end

    // Register writes for the addressed bank; unmapped words are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                oe_q[b]   <= '0;
                inv_q[b]  <= '0;
                val_q[b]  <= '0;
                rise_q[b] <= '0;
                fall_q[b] <= '0;
                high_q[b] <= '0;
                low_q[b]  <= '0;
            end
        end else if (wr_en && hit) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bsel == 2'(b)) begin
                    case (grp)
                        GRP_OE:   oe_q[b]   <= wr_data[BANK_W-1:0];
                        GRP_INV:  inv_q[b]  <= wr_data[BANK_W-1:0];
                        GRP_VAL:  val_q[b]  <= wr_data[BANK_W-1:0];
                        GRP_SET:  val_q[b]  <= val_q[b] | wr_data[BANK_W-1:0];
                        GRP_CLR:  val_q[b]  <= val_q[b] & ~wr_data[BANK_W-1:0];
                        GRP_RISE: rise_q[b] <= wr_data[BANK_W-1:0];
                        GRP_FALL: fall_q[b] <= wr_data[BANK_W-1:0];
                        GRP_HIGH: high_q[b] <= wr_data[BANK_W-1:0];
                        GRP_LOW:  low_q[b]  <= wr_data[BANK_W-1:0];
                        default:  ;
                    endcase
                end
            end
        end
    end

    // Combinational read mux; set/clear and unmapped words read zero.
    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit && bsel == 2'(b)) begin
                case (grp)
                    GRP_OE:    rd_data = WORD_W'(oe_q[b]);
                    GRP_INV:   rd_data = WORD_W'(inv_q[b]);
                    GRP_VAL:   rd_data = WORD_W'((val_q[b] & oe_q[b]) | (sync_w[b] & ~oe_q[b]));
                    GRP_RISE:  rd_data = WORD_W'(rise_q[b]);
                    GRP_FALL:  rd_data = WORD_W'(fall_q[b]);
                    GRP_HIGH:  rd_data = WORD_W'(high_q[b]);
                    GRP_LOW:   rd_data = WORD_W'(low_q[b]);
                    GRP_PEND:  rd_data = WORD_W'(pend_w[b]);
                    GRP_EMARK: rd_data = WORD_W'(emark_w[b]);
                    default:   rd_data = '0;
                endcase
            end
        end
    end

    // Shared interrupt: any pending bit in any bank.
    always_comb begin
        irq = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            irq = irq | (|pend_w[b]);
        end
    end

endmodule

// File: rtl/gpio_ctrl_checker.sv
// Port-level assertions for gpio_bank_ctrl, attached by bind.
// Assumes the default 32-bit banks; checks bank 0 for write effects.
module gpio_ctrl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  addr,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic [95:0] pin_out,
    input logic [95:0] pin_oe,
    input logic        irq
);

    // R1: reset leaves outputs and interrupt low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq == 1'b0 && pin_oe == '0 && pin_out == '0));

    // R2: bank field 3 is unmapped and reads zero.
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[3:2] == 2'b11) |-> (rd_data == 32'h0));

    // R3: an enable write to bank 0 appears on pin_oe.
    assert_oe_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h00) |=> (pin_oe[31:0] == $past(wr_data)));

    // R4: set word ORs ones into bank 0 outputs.
    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h30) |=> (pin_out[31:0] == ($past(pin_out[31:0]) | $past(wr_data))));

    // R4: clear word removes ones from bank 0 outputs.
    assert_clr_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 8'h40) |=> (pin_out[31:0] == ($past(pin_out[31:0]) & ~$past(wr_data))));

    // R4: set and clear words read back as zero.
    assert_setclr_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[7:4] == 4'h3 || addr[7:4] == 4'h4) |-> (rd_data == 32'h0));

    // R10: irq only drops after a write to a pending word.
    assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && addr[7:4] == 4'h9)) |=> irq);

endmodule

bind gpio_bank_ctrl gpio_ctrl_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/gpio_bank_ctrl_bench.sv
// Directed bench for gpio_bank_ctrl: one task per scenario.
module gpio_bank_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [95:0] pin_in = '0;
    logic [95:0] pin_out;
    logic [95:0] pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq", 96'(irq), 96'h0);
        check("R1 pin_oe", pin_oe, 96'h0);
        check("R1 pin_out", pin_out, 96'h0);
        rd(8'h94, v);
        check("R1 pending bank1", 96'(v), 96'h0);
    endtask

    task automatic t_oe_val();
        logic [31:0] v;
        wr(8'h00, 32'h0000FFFF);
        wr(8'h20, 32'h12345678);
        check("R3 pin_oe bank0", 96'(pin_oe[31:0]), 96'h0000FFFF);
        check("R3 pin_out bank0", 96'(pin_out[31:0]), 96'h12345678);
        @(negedge clk);
        pin_in[31:0] = 32'hABCD0000;
        settle();
        rd(8'h20, v);
        check("R3 mixed readback", 96'(v), 96'hABCD5678);
    endtask

    task automatic t_set_clr();
        logic [31:0] v;
        wr(8'h34, 32'h000000F0);
        check("R4 set bank1", 96'(pin_out[63:32]), 96'hF0);
        wr(8'h44, 32'h00000030);
        check("R4 clear bank1", 96'(pin_out[63:32]), 96'hC0);
        check("R4 bank0 untouched", 96'(pin_out[31:0]), 96'h12345678);
        rd(8'h34, v);
        check("R4 set word reads zero", 96'(v), 96'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        logic [95:0] oe_before;
        oe_before = pin_oe;
        wr(8'h0C, 32'hFFFFFFFF);
        check("R2 bank3 write ignored", pin_oe, oe_before);
        rd(8'h0C, v);
        check("R2 bank3 reads zero", 96'(v), 96'h0);
        rd(8'h01, v);
        check("R2 misaligned reads zero", 96'(v), 96'h0);
        wr(8'hB0, 32'hFFFFFFFF);
        check("R2 group B write ignored", pin_oe, oe_before);
        wr(8'h08, 32'h000000A5);
        check("R2 bank2 stride", 96'(pin_oe[95:64]), 96'hA5);
        rd(8'h08, v);
        check("R2 bank2 readback", 96'(v), 96'hA5);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(8'h58, 32'h00000008);
        @(negedge clk);
        pin_in[67] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R5 no pending after two edges", 96'(irq), 96'h0);
        @(negedge clk);
        check("R5 pending on third edge", 96'(irq), 96'h1);
        rd(8'h98, v);
        check("R5 pending bank2", 96'(v), 96'h8);
        rd(8'hA8, v);
        check("R8 edge mark set", 96'(v), 96'h8);
        wr(8'hA8, 32'hFFFFFFFF);
        rd(8'hA8, v);
        check("R8 edge mark write ignored", 96'(v), 96'h8);
        wr(8'h98, 32'h00000008);
        settle();
        rd(8'h98, v);
        check("R5 held high does not re-set", 96'(v), 96'h0);
        rd(8'hA8, v);
        check("R8 edge mark cleared", 96'(v), 96'h0);
        check("R10 irq low after clear", 96'(irq), 96'h0);
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        wr(8'h68, 32'h00000008);
        @(negedge clk);
        pin_in[67] = 1'b0;
        settle();
        rd(8'h98, v);
        check("R6 falling edge", 96'(v), 96'h8);
        wr(8'h98, 32'h00000008);
        @(negedge clk);
        pin_in[67] = 1'b1;
        settle();
        rd(8'h98, v);
        check("R6 both edges rising", 96'(v), 96'h8);
        wr(8'h98, 32'h00000008);
        @(negedge clk);
        pin_in[67] = 1'b0;
        settle();
        rd(8'h98, v);
        check("R6 both edges falling", 96'(v), 96'h8);
        wr(8'h58, 32'h0);
        wr(8'h68, 32'h0);
        wr(8'h98, 32'h00000008);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(8'h74, 32'h00000020);
        @(negedge clk);
        pin_in[37] = 1'b1;
        settle();
        rd(8'h94, v);
        check("R7 high level", 96'(v), 96'h20);
        rd(8'hA4, v);
        check("R8 level leaves no edge mark", 96'(v), 96'h0);
        wr(8'h94, 32'h00000020);
        rd(8'h94, v);
        check("R11 clear loses to held level", 96'(v), 96'h20);
        wr(8'h74, 32'h0);
        wr(8'h94, 32'h00000020);
        rd(8'h94, v);
        check("R8 clear after disable", 96'(v), 96'h0);
        @(negedge clk);
        pin_in[37] = 1'b0;
        wr(8'h84, 32'h00000020);
        settle();
        rd(8'h94, v);
        check("R7 low level", 96'(v), 96'h20);
        wr(8'h84, 32'h0);
        wr(8'h94, 32'h00000020);
        rd(8'h94, v);
        check("R8 low cleared", 96'(v), 96'h0);
    endtask

    task automatic t_invert();
        logic [31:0] v;
        wr(8'h70, 32'h00100000);
        settle();
        rd(8'h90, v);
        check("R9 quiet pin not high", 96'(v), 96'h0);
        wr(8'h10, 32'h00100000);
        settle();
        rd(8'h90, v);
        check("R9 inverted pin is high", 96'(v), 96'h00100000);
        rd(8'h10, v);
        check("R9 inversion readback", 96'(v), 96'h00100000);
        rd(8'h20, v);
        check("R9 data read uninverted", 96'(v), 96'hABCD5678);
    endtask

    task automatic t_shared_irq();
        logic [31:0] v;
        wr(8'h54, 32'h00000020);
        @(negedge clk);
        pin_in[37] = 1'b1;
        settle();
        rd(8'h94, v);
        check("R10 bank1 pending", 96'(v), 96'h20);
        wr(8'h70, 32'h0);
        wr(8'h90, 32'h00100000);
        rd(8'h90, v);
        check("R10 bank0 cleared", 96'(v), 96'h0);
        check("R10 irq held by bank1", 96'(irq), 96'h1);
        wr(8'h94, 32'h00000020);
        check("R10 irq low when all clear", 96'(irq), 96'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_oe_val();
        t_set_clr();
        t_map();
        t_rise();
        t_fall_both();
        t_level();
        t_invert();
        t_shared_irq();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule